// File: doc/BRIEF.md
# Field-Synchronous Shadow Register Bank

This block holds the control registers of a video output path behind a plain register write port. Some of those registers steer processing that must not change in the middle of a picture. For those registers a host write can be held in a shadow copy. It is then moved to the active copy in one step, once per field, when a strobe from the timing logic marks the point just before active video begins.

There are two video domains, high definition (HD) and standard definition (SD). Each domain has its own double-buffer enable. When a domain's enable is clear, its registers behave like ordinary registers. Registers outside the buffered set always update at once. One SD register is split: its low six bits follow the SD shadow path and its top two bits update at once. Reads always return the most recently written value. The active values leave the block on a flat bus that feeds the downstream video logic.

Top module: `fsrb_top`

## Requirements
- R1: After reset every register reads zero and drives zero on its active copy, except addresses 0x0A, 0x0B and 0x0C, which reset to 0x80.
- R2: Address 0x00 holds the enables: bit 0 enables double buffering for the HD domain (addresses 0x01 to 0x05), and bit 1 enables it for the SD domain (addresses 0x06 to 0x0F).
- R3: While a domain's enable is set, a write to one of its buffered bits leaves the active copy unchanged until that domain's next commit.
- R4: A commit happens on the clock edge where field_start is high after having been low in the previous cycle. At that edge the active copy takes the shadow value, so when several writes arrive within one field, only the last one is committed.
- R5: At most one commit happens per rising edge of field_start. A write made while field_start stays high after a commit waits for the next rising edge.
- R6: The two domains commit independently. Each domain's commit is gated by its own enable, and a write to one domain's enable does not change how the other domain's registers behave.
- R7: While a domain's enable is clear, a write to its registers reaches the active copy at the same clock edge as the write.
- R8: Address 0x00 and addresses 0x10 to 0x1F update their active copy at the write edge, whatever the enables are.
- R9: At address 0x0F, bits [5:0] are SD-buffered and bits [7:6] update at the write edge.
- R10: rd_data returns, combinationally, the most recently written (shadow) value of rd_addr, even when that value is not yet active.
- R11: A buffered write made in the same cycle as its domain's commit is included in that commit.
- R12: A write to the enables takes effect from the next cycle. When a domain's enable is cleared, a value still pending in its shadow reaches the active copy one cycle after the write to address 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | ADDR_W (5) | Write address |
| wr_data | input | DATA_W (8) | Write data |
| rd_addr | input | ADDR_W (5) | Read address |
| rd_data | output | DATA_W (8) | Shadow value at rd_addr |
| field_start | input | 1 | High from the point just before active video; its rising edge triggers a commit |
| act_regs | output | 2^ADDR_W x DATA_W | Active copies; register n is at bits [n*DATA_W +: DATA_W] |

## Verification
A host write and a field commit can land on the same clock edge. If they do, the written value must be the one that becomes active. The bench provokes this by driving a write to the SD brightness register in the same cycle as the rising edge of field_start. It then expects the new value on the active bus one edge later. A second overlap is a write to the enables that clears a domain's enable while that domain still has a pending shadow value. The bench checks that the old active value holds at the write edge and that the pending value appears exactly one edge later.

// File: rtl/fsrb_pkg.sv
package fsrb_pkg;
  localparam int REG_W     = 8;
  localparam int ADDR_W    = 5;
  localparam int EN_HD_BIT = 0;
  localparam int EN_SD_BIT = 1;

  localparam int A_CTRL    = 0;
  localparam int A_HD_LO   = 1;   // HD gamma pair A/B and copy-protection signalling
  localparam int A_HD_HI   = 5;
  localparam int A_SD_LO   = 6;   // SD gamma, scales, brightness, captions, protection
  localparam int A_SD_HI   = 15;
  localparam int A_SD_SPLIT = 15; // only low bits buffered
  localparam int A_SCALE_LO = 10;
  localparam int A_SCALE_HI = 12;

  typedef enum logic [1:0] {DOM_NONE, DOM_HD, DOM_SD} dom_e;

  function automatic dom_e reg_dom(input int a);
    if (a >= A_HD_LO && a <= A_HD_HI) return DOM_HD;
    if (a >= A_SD_LO && a <= A_SD_HI) return DOM_SD;
    return DOM_NONE;
  endfunction

  function automatic logic [REG_W-1:0] buf_mask(input int a);
    if (reg_dom(a) == DOM_NONE) return '0;
    if (a == A_SD_SPLIT) return REG_W'(8'h3F);
    return '1;
  endfunction

  function automatic logic [REG_W-1:0] rst_val(input int a);
    if (a >= A_SCALE_LO && a <= A_SCALE_HI) return REG_W'(8'h80);
    return '0;
  endfunction
endpackage

// File: rtl/fsrb_commit_gen.sv
module fsrb_commit_gen #(
  parameter int N_DOM = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             field_start,
  input  logic [N_DOM-1:0] dom_en,
  output logic [N_DOM-1:0] commit
);
  logic sof_q;
  logic sof_edge;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sof_q <= 1'b0;
    else        sof_q <= field_start;
  end

  assign sof_edge = field_start & ~sof_q;

  for (genvar d = 0; d < N_DOM; d++) begin : g_dom
    assign commit[d] = sof_edge & dom_en[d];

    // R5: one commit per rising edge of the field strobe
    p_single_commit_r5: assert property (@(posedge clk) disable iff (!rst_n)
      commit[d] |=> !commit[d]);
  end
endmodule

// File: rtl/fsrb_reg_cell.sv
module fsrb_reg_cell #(
  parameter int             W        = 8,
  parameter logic [W-1:0]   RST      = '0,
  parameter logic [W-1:0]   BUF_MASK = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_hit,
  input  logic [W-1:0] wr_data,
  input  logic         dbuf_en,
  input  logic         commit,
  output logic [W-1:0] shadow,
  output logic [W-1:0] active
);
  localparam logic [W-1:0] DIRECT_MASK = ~BUF_MASK;

  logic [W-1:0] shadow_nx;
  logic [W-1:0] active_nx;
  logic         take;

  always_comb begin
    shadow_nx = wr_hit ? wr_data : shadow;
    take      = commit | ~dbuf_en;
    active_nx = (shadow_nx & DIRECT_MASK) | ((take ? shadow_nx : active) & BUF_MASK);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow <= RST;
      active <= RST;
    end else begin
      shadow <= shadow_nx;
      active <= active_nx;
    end
  end

  if (BUF_MASK != '0) begin : g_buf_chk
    // R3: buffered bits hold between commits while enabled
    p_hold_active_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (dbuf_en && !commit) |=> $stable(active & BUF_MASK));
    // R4: a commit exposes the shadow on the buffered bits
    p_commit_copies_r4: assert property (@(posedge clk) disable iff (!rst_n)
      commit |=> ((active & BUF_MASK) == (shadow & BUF_MASK)));
    // R7: disabled domain tracks the written value
    p_direct_when_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !dbuf_en |=> (active == shadow));
  end

  if (DIRECT_MASK != '0) begin : g_dir_chk
    // R8: unbuffered bits follow the write at once
    p_unbuf_immediate_r8: assert property (@(posedge clk) disable iff (!rst_n)
      wr_hit |=> ((active & DIRECT_MASK) == ($past(wr_data) & DIRECT_MASK)));
  end
endmodule

// File: rtl/fsrb_read_mux.sv
module fsrb_read_mux #(
  parameter int W      = 8,
  parameter int ADDR_W = 5,
  localparam int N     = 1 << ADDR_W
) (
  input  logic [N*W-1:0]    shadow_flat,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [W-1:0]      rd_data
);
  logic [W-1:0] words [N];

  for (genvar i = 0; i < N; i++) begin : g_word
    assign words[i] = shadow_flat[i*W +: W];
  end

  assign rd_data = words[rd_addr];
endmodule

// File: rtl/fsrb_top.sv
module fsrb_top #(
  parameter int DATA_W = fsrb_pkg::REG_W,
  parameter int ADDR_W = fsrb_pkg::ADDR_W,
  localparam int NUM_REGS = 1 << ADDR_W
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [ADDR_W-1:0]          wr_addr,
  input  logic [DATA_W-1:0]          wr_data,
  input  logic [ADDR_W-1:0]          rd_addr,
  output logic [DATA_W-1:0]          rd_data,
  input  logic                       field_start,
  output logic [NUM_REGS*DATA_W-1:0] act_regs
);
  import fsrb_pkg::*;

  localparam int N_DOM = 2;
  localparam int D_HD  = 0;
  localparam int D_SD  = 1;

  logic [NUM_REGS*DATA_W-1:0] shadow_flat;
  logic [N_DOM-1:0]           dom_en;
  logic [N_DOM-1:0]           commit;

  // enables come from the active copy of the control register (R2, R12)
  assign dom_en[D_HD] = act_regs[A_CTRL*DATA_W + EN_HD_BIT];
  assign dom_en[D_SD] = act_regs[A_CTRL*DATA_W + EN_SD_BIT];

  fsrb_commit_gen #(.N_DOM(N_DOM)) u_commit (
    .clk         (clk),
    .rst_n       (rst_n),
    .field_start (field_start),
    .dom_en      (dom_en),
    .commit      (commit)
  );

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    localparam dom_e DOM = reg_dom(i);
    logic hit, en_i, cm_i;

    assign hit = wr_en && (wr_addr == ADDR_W'(i));

    if (DOM == DOM_HD) begin : g_hd
      assign en_i = dom_en[D_HD];
      assign cm_i = commit[D_HD];
    end else if (DOM == DOM_SD) begin : g_sd
      assign en_i = dom_en[D_SD];
      assign cm_i = commit[D_SD];
    end else begin : g_plain
      assign en_i = 1'b0;
      assign cm_i = 1'b0;
    end

    fsrb_reg_cell #(
      .W        (DATA_W),
      .RST      (DATA_W'(rst_val(i))),
      .BUF_MASK (DATA_W'(buf_mask(i)))
    ) u_cell (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_hit  (hit),
      .wr_data (wr_data),
      .dbuf_en (en_i),
      .commit  (cm_i),
      .shadow  (shadow_flat[i*DATA_W +: DATA_W]),
      .active  (act_regs[i*DATA_W +: DATA_W])
    );
  end

  fsrb_read_mux #(.W(DATA_W), .ADDR_W(ADDR_W)) u_rd (
    .shadow_flat (shadow_flat),
    .rd_addr     (rd_addr),
    .rd_data     (rd_data)
  );
endmodule

// File: tb/fsrb_top_test.sv
`timescale 1ns/1ps
module fsrb_top_test;
  localparam int CLK_PERIOD = 20;
  localparam int WD_LIMIT   = 5000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [4:0]  rd_addr = '0;
  logic [7:0]  rd_data;
  logic        field_start = 1'b0;
  logic [255:0] act_regs;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  typedef struct {
    bit         is_rd;
    int         addr;
    logic [7:0] val;
    string      tag;
  } item_t;

  item_t sb[$];

  fsrb_top uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .field_start(field_start), .act_regs(act_regs)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic exp_act(input int a, input logic [7:0] v, input string tag);
    item_t it;
    it.is_rd = 1'b0; it.addr = a; it.val = v; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic exp_rd(input int a, input logic [7:0] v, input string tag);
    item_t it;
    it.is_rd = 1'b1; it.addr = a; it.val = v; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic step(input bit we, input int a, input logic [7:0] d, input bit fs);
    @(negedge clk);
    wr_en = we; wr_addr = a[4:0]; wr_data = d; field_start = fs;
  endtask

  // monitor: after each rising edge, pop and compare queued expectations
  initial begin
    forever begin
      @(posedge clk);
      #3;
      while (sb.size() > 0) begin
        item_t it;
        logic [7:0] got;
        it = sb.pop_front();
        if (it.is_rd) begin
          rd_addr = it.addr[4:0];
          #1;
          got = rd_data;
        end else begin
          got = act_regs[it.addr*8 +: 8];
        end
        checks++;
        if (got !== it.val) begin
          fails++;
          $display("FAIL %s addr=0x%02h actual=0x%02h expected=0x%02h",
                   it.tag, it.addr, got, it.val);
        end
      end
    end
  end

  // watchdog
  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > WD_LIMIT) begin
        checks++; fails++;
        $display("FAIL watchdog actual=%0d expected<=%0d cycles", cycles, WD_LIMIT);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    exp_act(8'h0A, 8'h80, "R1");
    exp_rd (8'h0B, 8'h80, "R1");
    exp_act(8'h01, 8'h00, "R1");
    exp_act(8'h0F, 8'h00, "R1");

    // R7: HD disabled, write is active at once
    step(1, 8'h01, 8'h11, 0);  exp_act(8'h01, 8'h11, "R7");
    // R2/R8: enable both domains, control register immediate
    step(1, 8'h00, 8'h03, 0);  exp_act(8'h00, 8'h03, "R8");
    // R3/R10: buffered write held, read shows shadow
    step(1, 8'h05, 8'hA5, 0);  exp_act(8'h05, 8'h00, "R3"); exp_rd(8'h05, 8'hA5, "R10");
    step(1, 8'h05, 8'h5A, 0);  exp_act(8'h05, 8'h00, "R3");
    step(0, 0, 8'h00, 0);      exp_act(8'h05, 8'h00, "R2");
    // R4: commit takes last write
    step(0, 0, 8'h00, 1);      exp_act(8'h05, 8'h5A, "R4");
    // R5: strobe held high, no second commit
    step(1, 8'h05, 8'h77, 1);  exp_act(8'h05, 8'h5A, "R5");
    step(0, 0, 8'h00, 0);      exp_act(8'h05, 8'h5A, "R5");
    step(0, 0, 8'h00, 1);      exp_act(8'h05, 8'h77, "R5");
    step(0, 0, 8'h00, 0);

    // R6/R12: pending values in both domains, then drop HD enable
    step(1, 8'h0A, 8'h40, 0);  exp_act(8'h0A, 8'h80, "R3");
    step(1, 8'h02, 8'h22, 0);  exp_act(8'h02, 8'h00, "R3");
    step(1, 8'h00, 8'h02, 0);  exp_act(8'h02, 8'h00, "R12");
    step(0, 0, 8'h00, 0);      exp_act(8'h02, 8'h22, "R12"); exp_act(8'h0A, 8'h80, "R6");
    step(1, 8'h03, 8'h33, 0);  exp_act(8'h03, 8'h33, "R6");
    step(0, 0, 8'h00, 1);      exp_act(8'h0A, 8'h40, "R6");
    step(0, 0, 8'h00, 0);

    // R9: split register
    step(1, 8'h0F, 8'hFF, 0);  exp_act(8'h0F, 8'hC0, "R9");
    step(0, 0, 8'h00, 1);      exp_act(8'h0F, 8'hFF, "R9");
    step(1, 8'h0F, 8'h01, 0);  exp_act(8'h0F, 8'h3F, "R9");
    step(0, 0, 8'h00, 1);      exp_act(8'h0F, 8'h01, "R9");
    step(0, 0, 8'h00, 0);

    // R8: plain register with SD enabled
    step(1, 8'h15, 8'h9C, 0);  exp_act(8'h15, 8'h9C, "R8"); exp_rd(8'h15, 8'h9C, "R10");
    // R11: write coincides with commit
    step(1, 8'h0D, 8'h5D, 1);  exp_act(8'h0D, 8'h5D, "R11");
    step(0, 0, 8'h00, 0);      exp_act(8'h0D, 8'h5D, "R11");

    repeat (3) @(posedge clk);
    #8;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule